// File: doc/BRIEF.md
# External Memory Bus Sequencer with Bus Hold

This block sits between a 16-bit processor core and an external parallel memory bus. The core presents a request with a 24-bit address, write data, two byte enables and a direction flag. When the address lies above the internal region, the block runs an external bus cycle. Each cycle has a one-clock latch-enable pulse that carries the address. A read or write strobe phase follows, and a ready input can hold that phase open. Four active-low select lines mark which fixed address window is being accessed.

The data bus is 16 bits or 8 bits wide. A global mode input sets the width. In 16-bit mode, any of windows 1 to 3 can be forced to 8 bits by its own configuration bit. In 8-bit mode a word access runs as two byte cycles on the low lane, even address first. An external master may ask for the bus with an active-low hold request. The block grants the bus only between bus cycles. While the bus is granted, all bus outputs are released through two output-enable signals. Core requests to the internal region are never stalled.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset all strobes and selects are high, `addr_lat` and `done` are low, `hold_ack_n` is high and `ctl_oe` is high.
- R2: A read drives only `rstb_n` low. A write drives only the write strobes low. The two kinds of strobe are never low together, and `dat_oe` is high only during write accesses.
- R3: Every byte or word cycle starts with `addr_lat` high for exactly one clock, with `bus_addr` valid. The strobe falls on the next clock. While `addr_lat` is high, all strobes are high.
- R4: A strobe stays low for one clock plus one extra clock for each rising edge at which `bus_ready` is sampled low while the strobe is low.
- R5: A low `hold_req_n` during an access is granted only after the access completes. `hold_ack_n` falls one clock after the `done` pulse, and never while a strobe or select is active.
- R6: While `hold_ack_n` is low, `ctl_oe` and `dat_oe` are low.
- R7: When `hold_req_n` returns high, `hold_ack_n` and `ctl_oe` rise in the same clock with `addr_lat` low. A pending external access raises `addr_lat` exactly one clock later.
- R8: Requests to addresses below 0x010000 are internal and never raise `busy`, not even during hold. External requests see `busy` high while hold is in force.
- R9: 16-bit width: one cycle at the address with bit 0 cleared. `wstb_lo_n` and `wstb_hi_n` follow `req_be[0]` and `req_be[1]`, `bus_dout` carries the whole word, and a read returns all 16 bits of `bus_din`.
- R10: 8-bit width applies when `bus8_mode` is 1, or when the selected window k (1 to 3) has `area8_sel[k-1]` set. `req_be` 2'b11 gives two cycles, even then odd address. 2'b01 gives only the even cycle, and 2'b10 gives only the odd cycle. The write byte goes out on `bus_dout[7:0]` (low byte for even, high byte for odd), `wstb_hi_n` stays high, and read bytes from `bus_din[7:0]` go to the matching lane of `rd_data`.
- R11: `sel_n[k]` is low from the latch pulse to the end of an access whose address satisfies (addr & 0xF00000) == (k+1)*0x100000. An address in no window leaves all selects high. At most one select is low.
- R12: `done` is a single-clock pulse at completion. For reads, `rd_data` holds the assembled data, with lanes not read set to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (bit 0 low byte) |
| req_write | input | 1 | 1 write, 0 read |
| busy | output | 1 | External request cannot be taken this clock |
| done | output | 1 | External access completed |
| rd_data | output | 16 | Read result, valid with done |
| bus8_mode | input | 1 | 1 selects 8-bit bus globally |
| area8_sel | input | 3 | Per-window 8-bit select for windows 1..3 |
| bus_ready | input | 1 | Low stretches the strobe phase |
| hold_req_n | input | 1 | Low requests the bus, high releases it |
| hold_ack_n | output | 1 | Low while bus is granted away |
| bus_addr | output | 24 | Bus address |
| bus_dout | output | 16 | Bus write data |
| bus_din | input | 16 | Bus read data |
| ctl_oe | output | 1 | Drive enable for address, strobes, latch, selects |
| dat_oe | output | 1 | Drive enable for write data |
| addr_lat | output | 1 | Address latch pulse, high active |
| rstb_n | output | 1 | Read strobe |
| wstb_lo_n | output | 1 | Low-byte write strobe |
| wstb_hi_n | output | 1 | High-byte write strobe |
| sel_n | output | 4 | Window selects |

## Verification
A hold request can arrive while the strobe is held open by a low ready. That is the case where hold arbitration and the ready stretch meet. The bench lowers `hold_req_n` in the first stretched strobe clock of random accesses. It then checks that the grant stays off through the stretch and the `done` pulse, and that it appears exactly one clock later. A queued external request is also held through the release. The bench checks that `hold_ack_n` rising, the return of drive and a low latch pulse share one clock, and that the latch pulse comes on the next clock.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_STRB = 2'd2
  } sq_state_t;
endpackage

// File: rtl/ebc_cs_decode.sv
module ebc_cs_decode #(
  parameter int AW = 24,
  parameter int NCS = 4,
  parameter logic [NCS*AW-1:0] CS_BASE = '0,
  parameter logic [NCS*AW-1:0] CS_MASK = '0
) (
  input  logic [AW-1:0]  addr,
  input  logic           bus8_mode,
  input  logic [NCS-2:0] area8_sel,
  output logic [NCS-1:0] hit,
  output logic           narrow
);
  logic [NCS-1:0] raw;

  for (genvar k = 0; k < NCS; k++) begin : g_win
    assign raw[k] = ((addr & CS_MASK[k*AW +: AW]) == CS_BASE[k*AW +: AW]);
    if (k == 0) begin : g_first
      assign hit[k] = raw[k];
    end else begin : g_rest
      assign hit[k] = raw[k] & ~(|raw[k-1:0]);
    end
  end

  // window 0 follows the global width only
  assign narrow = bus8_mode | (|(hit[NCS-1:1] & area8_sel));
endmodule

// File: rtl/ebc_hold_ctl.sv
module ebc_hold_ctl (
  input  logic clk,
  input  logic rst,
  input  logic hold_req_n,
  input  logic seq_idle,
  output logic hold_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else if (!hold_q && seq_idle && !hold_req_n) begin
      hold_q <= 1'b1;
    end else if (hold_q && hold_req_n) begin
      hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  s_addr,
  input  logic [DW-1:0]  s_wdata,
  input  logic [1:0]     s_be,
  input  logic           s_wr,
  input  logic           s_narrow,
  input  logic [NCS-1:0] s_sel_n,
  input  logic           rdy,
  input  logic [DW-1:0]  din,
  output logic           idle,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  dout_o,
  output logic           lat_o,
  output logic           rstb_n_o,
  output logic           wlo_n_o,
  output logic           whi_n_o,
  output logic [NCS-1:0] sel_n_o,
  output logic           dat_oe_o,
  output logic           done_o,
  output logic [DW-1:0]  rdata_o
);
  localparam int BW = DW / 2;

  sq_state_t      st;
  logic           second_q, hi_lane_q, narrow_q, wr_q;
  logic [1:0]     be_q;
  logic [DW-1:0]  wdata_q;

  assign idle = (st == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      lat_o     <= 1'b0;
      rstb_n_o  <= 1'b1;
      wlo_n_o   <= 1'b1;
      whi_n_o   <= 1'b1;
      sel_n_o   <= '1;
      dat_oe_o  <= 1'b0;
      done_o    <= 1'b0;
      addr_o    <= '0;
      dout_o    <= '0;
      rdata_o   <= '0;
      second_q  <= 1'b0;
      hi_lane_q <= 1'b0;
      narrow_q  <= 1'b0;
      wr_q      <= 1'b0;
      be_q      <= '0;
      wdata_q   <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            narrow_q <= s_narrow;
            wr_q     <= s_wr;
            be_q     <= s_be;
            wdata_q  <= s_wdata;
            sel_n_o  <= s_sel_n;
            dat_oe_o <= s_wr;
            lat_o    <= 1'b1;
            rdata_o  <= '0;
            st       <= SQ_ADDR;
            if (s_narrow && s_be == 2'b10) begin
              addr_o    <= {s_addr[AW-1:1], 1'b1};
              dout_o    <= {s_wdata[DW-1:BW], s_wdata[DW-1:BW]};
              hi_lane_q <= 1'b1;
              second_q  <= 1'b0;
            end else begin
              addr_o    <= {s_addr[AW-1:1], 1'b0};
              dout_o    <= s_wdata;
              hi_lane_q <= 1'b0;
              second_q  <= s_narrow & (&s_be);
            end
          end
        end
        SQ_ADDR: begin
          lat_o    <= 1'b0;
          rstb_n_o <= wr_q;
          wlo_n_o  <= !(wr_q && (narrow_q || be_q[0]));
          whi_n_o  <= !(wr_q && !narrow_q && be_q[1]);
          st       <= SQ_STRB;
        end
        SQ_STRB: begin
          if (rdy) begin
            rstb_n_o <= 1'b1;
            wlo_n_o  <= 1'b1;
            whi_n_o  <= 1'b1;
            if (!wr_q) begin
              if (!narrow_q) begin
                rdata_o <= din;
              end else if (hi_lane_q) begin
                rdata_o[DW-1:BW] <= din[BW-1:0];
              end else begin
                rdata_o[BW-1:0] <= din[BW-1:0];
              end
            end
            if (second_q) begin
              second_q  <= 1'b0;
              hi_lane_q <= 1'b1;
              addr_o    <= {addr_o[AW-1:1], 1'b1};
              dout_o    <= {wdata_q[DW-1:BW], wdata_q[DW-1:BW]};
              lat_o     <= 1'b1;
              st        <= SQ_ADDR;
            end else begin
              st       <= SQ_IDLE;
              done_o   <= 1'b1;
              sel_n_o  <= '1;
              dat_oe_o <= 1'b0;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int NCS = 4,
  parameter logic [AW-1:0] INT_TOP = 24'h010000,
  parameter logic [NCS*AW-1:0] CS_BASE = {24'h400000, 24'h300000, 24'h200000, 24'h100000},
  parameter logic [NCS*AW-1:0] CS_MASK = {24'hF00000, 24'hF00000, 24'hF00000, 24'hF00000}
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [1:0]     req_be,
  input  logic           req_write,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  rd_data,
  input  logic           bus8_mode,
  input  logic [NCS-2:0] area8_sel,
  input  logic           bus_ready,
  input  logic           hold_req_n,
  output logic           hold_ack_n,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_dout,
  input  logic [DW-1:0]  bus_din,
  output logic           ctl_oe,
  output logic           dat_oe,
  output logic           addr_lat,
  output logic           rstb_n,
  output logic           wstb_lo_n,
  output logic           wstb_hi_n,
  output logic [NCS-1:0] sel_n
);
  logic [NCS-1:0] hit;
  logic           narrow, seq_idle, hold_q, is_ext, can_go, start, seq_dat_oe;

  ebc_cs_decode #(.AW(AW), .NCS(NCS), .CS_BASE(CS_BASE), .CS_MASK(CS_MASK)) u_dec (
    .addr(req_addr), .bus8_mode(bus8_mode), .area8_sel(area8_sel),
    .hit(hit), .narrow(narrow)
  );

  ebc_hold_ctl u_hold (
    .clk(clk), .rst(rst), .hold_req_n(hold_req_n), .seq_idle(seq_idle), .hold_q(hold_q)
  );

  assign is_ext = (req_addr >= INT_TOP);
  assign can_go = seq_idle && !hold_q && hold_req_n;
  assign start  = req_valid && is_ext && can_go;
  assign busy   = req_valid && is_ext && !can_go;

  ebc_seq #(.AW(AW), .DW(DW), .NCS(NCS)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .s_addr(req_addr), .s_wdata(req_wdata), .s_be(req_be), .s_wr(req_write),
    .s_narrow(narrow), .s_sel_n(~hit),
    .rdy(bus_ready), .din(bus_din),
    .idle(seq_idle), .addr_o(bus_addr), .dout_o(bus_dout), .lat_o(addr_lat),
    .rstb_n_o(rstb_n), .wlo_n_o(wstb_lo_n), .whi_n_o(wstb_hi_n),
    .sel_n_o(sel_n), .dat_oe_o(seq_dat_oe), .done_o(done), .rdata_o(rd_data)
  );

  assign hold_ack_n = !hold_q;
  assign ctl_oe     = !hold_q;
  assign dat_oe     = seq_dat_oe && !hold_q;
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
  parameter int AW = 24,
  parameter int NCS = 4,
  parameter logic [AW-1:0] INT_TOP = 24'h010000
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic [AW-1:0]  req_addr,
  input logic           busy,
  input logic           done,
  input logic           bus8_mode,
  input logic           bus_ready,
  input logic           hold_ack_n,
  input logic           ctl_oe,
  input logic           dat_oe,
  input logic           addr_lat,
  input logic           rstb_n,
  input logic           wstb_lo_n,
  input logic           wstb_hi_n,
  input logic [NCS-1:0] sel_n
);
  // R2
  strb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rstb_n && (!wstb_lo_n || !wstb_hi_n)));
  // R3
  lat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    addr_lat |-> (rstb_n && wstb_lo_n && wstb_hi_n));
  // R3
  lat_lead_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rstb_n) || $fell(wstb_lo_n) || $fell(wstb_hi_n)) |-> $past(addr_lat));
  // R4
  rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rstb_n && !bus_ready) |=> !rstb_n);
  // R4
  rdy_hold_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!wstb_lo_n && !bus_ready) |=> !wstb_lo_n);
  // R5
  hold_bound_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack_n) |-> ($past(sel_n) == '1 && $past(rstb_n) && $past(wstb_lo_n) && $past(wstb_hi_n)));
  // R6
  hold_float_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_ack_n |-> (!ctl_oe && !dat_oe));
  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack_n) |-> (ctl_oe && !addr_lat));
  // R8
  int_free_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr < INT_TOP) |-> !busy);
  // R10
  narrow_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (bus8_mode && $stable(bus8_mode)) |-> wstb_hi_n);
  // R11
  sel_one_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind ext_bus_ctrl ebc_chk #(.AW(AW), .NCS(NCS), .INT_TOP(INT_TOP)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .busy(busy),
  .done(done), .bus8_mode(bus8_mode), .bus_ready(bus_ready), .hold_ack_n(hold_ack_n),
  .ctl_oe(ctl_oe), .dat_oe(dat_oe), .addr_lat(addr_lat), .rstb_n(rstb_n),
  .wstb_lo_n(wstb_lo_n), .wstb_hi_n(wstb_hi_n), .sel_n(sel_n)
);

// File: tb/test_ext_bus_ctrl.sv
module test_ext_bus_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        req_write = 1'b0;
  logic        busy, done, hold_ack_n, ctl_oe, dat_oe, addr_lat;
  logic        rstb_n, wstb_lo_n, wstb_hi_n;
  logic [15:0] rd_data, bus_dout, bus_din;
  logic [23:0] bus_addr;
  logic [3:0]  sel_n;
  logic        bus8_mode = 1'b0;
  logic [2:0]  area8_sel = '0;
  logic        bus_ready = 1'b1;
  logic        hold_req_n = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] mem_f(input logic [23:0] a);
    return a[15:0] ^ {a[7:0], a[23:16]} ^ 16'h3C96;
  endfunction

  assign bus_din = mem_f(bus_addr);

  ext_bus_ctrl i_ext_bus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
    .busy(busy), .done(done), .rd_data(rd_data), .bus8_mode(bus8_mode),
    .area8_sel(area8_sel), .bus_ready(bus_ready), .hold_req_n(hold_req_n),
    .hold_ack_n(hold_ack_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_din(bus_din), .ctl_oe(ctl_oe), .dat_oe(dat_oe), .addr_lat(addr_lat),
    .rstb_n(rstb_n), .wstb_lo_n(wstb_lo_n), .wstb_hi_n(wstb_hi_n), .sel_n(sel_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // window index per R11, -1 for none
  function automatic int win_of(input logic [23:0] a);
    for (int k = 0; k < 4; k++)
      if ((a & 24'hF00000) == 24'(k + 1) * 24'h100000) return k;
    return -1;
  endfunction

  task automatic access(input logic [23:0] a, input logic [15:0] wd, input logic [1:0] be,
                        input logic wr, input logic b8, input logic [2:0] sel,
                        input bit stall_en, input bit hold_mid);
    int          w, nexp, ncyc, lat_cnt, guard, idx;
    bit          narrow, in_low, ack_ok;
    logic [23:0] e_addr [2];
    logic [23:0] c_addr [2];
    logic [15:0] c_dout [2];
    logic        c_rd [2], c_wl [2], c_wh [2];
    int          c_low [2], c_stall [2];
    logic [3:0]  c_sel [2];
    logic [3:0]  e_sel;
    logic [15:0] e_rd, got_rd;
    bit          e_wl, e_wh;
    logic [15:0] e_d;

    w = win_of(a);
    narrow = b8 || (w >= 1 && sel[w-1]);
    e_sel = (w < 0) ? 4'hF : ~(4'b0001 << w);
    if (!narrow) begin
      nexp = 1; e_addr[0] = {a[23:1], 1'b0};
    end else if (be == 2'b10) begin
      nexp = 1; e_addr[0] = {a[23:1], 1'b1};
    end else begin
      nexp = (be == 2'b11) ? 2 : 1;
      e_addr[0] = {a[23:1], 1'b0}; e_addr[1] = {a[23:1], 1'b1};
    end

    bus8_mode = b8; area8_sel = sel;
    if (!hold_ack_n) begin
      req_addr = 24'h001234; req_write = 1'b0; req_valid = 1'b1;
      #1 chk(!busy, "R8 internal not busy during hold", busy, 0);
      req_addr = a; req_wdata = wd; req_be = be; req_write = wr;
      #1 chk(busy, "R8 external busy during hold", busy, 1);
      step();
      chk(!ctl_oe && !dat_oe && busy, "R6 released outputs in hold", {ctl_oe, dat_oe, busy}, 3'b001);
      hold_req_n = 1'b1;
      step();
      chk(hold_ack_n && ctl_oe && !addr_lat, "R7 release same clock", {hold_ack_n, ctl_oe, addr_lat}, 3'b110);
      step();
      chk(addr_lat, "R7 latch one clock after release", addr_lat, 1);
    end else begin
      req_addr = a; req_wdata = wd; req_be = be; req_write = wr; req_valid = 1'b1;
      #1;
      guard = 0;
      while (busy && guard < 50) begin step(); guard++; end
      step();
    end
    req_valid = 1'b0;

    ncyc = 0; lat_cnt = 0; in_low = 0; ack_ok = 1; idx = 0;
    for (int i = 0; i < 2; i++) begin c_low[i] = 0; c_stall[i] = 0; c_sel[i] = 4'hF; end
    guard = 0;
    while (guard < 200) begin
      guard++;
      if (!hold_ack_n) ack_ok = 0;
      if (addr_lat) begin
        if (lat_cnt < 2) c_sel[lat_cnt] = sel_n;
        lat_cnt++;
      end
      if (!rstb_n || !wstb_lo_n || !wstb_hi_n) begin
        if (!in_low) begin
          idx = (ncyc < 2) ? ncyc : 1;
          ncyc++;
          c_addr[idx] = bus_addr; c_dout[idx] = bus_dout;
          c_rd[idx] = !rstb_n; c_wl[idx] = !wstb_lo_n; c_wh[idx] = !wstb_hi_n;
          in_low = 1;
          if (hold_mid) hold_req_n = 1'b0;
        end
        c_low[idx]++;
        bus_ready = (stall_en && ($urandom % 3 == 0)) ? 1'b0 : 1'b1;
        if (!bus_ready) c_stall[idx]++;
      end else begin
        in_low = 0; bus_ready = 1'b1;
      end
      if (done) break;
      step();
    end
    got_rd = rd_data;
    bus_ready = 1'b1;

    chk(ack_ok, "R5 no grant during access", ack_ok, 1);
    chk(lat_cnt == nexp, "R3 latch pulses per access", lat_cnt, nexp);
    chk(ncyc == nexp, narrow ? "R10 byte cycle count" : "R9 word cycle count", ncyc, nexp);
    for (int i = 0; i < nexp && i < ncyc; i++) begin
      chk(c_addr[i] == e_addr[i], narrow ? "R10 cycle address" : "R9 cycle address", c_addr[i], e_addr[i]);
      e_wl = wr && (narrow || be[0]);
      e_wh = wr && !narrow && be[1];
      chk({c_rd[i], c_wl[i], c_wh[i]} == {!wr, e_wl, e_wh}, "R2 strobe kind",
          {c_rd[i], c_wl[i], c_wh[i]}, {!wr, e_wl, e_wh});
      if (wr) begin
        e_d = narrow ? {8'h00, (e_addr[i][0] ? wd[15:8] : wd[7:0])} : wd;
        if (narrow) chk(c_dout[i][7:0] == e_d[7:0], "R10 write byte lane", c_dout[i][7:0], e_d[7:0]);
        else        chk(c_dout[i] == e_d, "R9 write word", c_dout[i], e_d);
      end
      chk(c_low[i] == 1 + c_stall[i], "R4 strobe length", c_low[i], 1 + c_stall[i]);
      chk(c_sel[i] == e_sel, "R11 window select", c_sel[i], e_sel);
    end
    if (!wr) begin
      if (!narrow) e_rd = mem_f({a[23:1], 1'b0});
      else begin
        e_rd = '0;
        if (be[0]) e_rd[7:0]  = mem_f({a[23:1], 1'b0})[7:0];
        if (be[1]) e_rd[15:8] = mem_f({a[23:1], 1'b1})[7:0];
      end
      chk(got_rd == e_rd, "R12 read data", got_rd, e_rd);
    end
    step();
    chk(!done && sel_n == 4'hF, "R12 done single pulse", {done, sel_n}, 5'h0F);
    if (hold_mid)
      chk(!hold_ack_n && !ctl_oe, "R5 grant one clock after done", {hold_ack_n, ctl_oe}, 2'b00);
  endtask

  initial begin
    void'($urandom(32'd1187));
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(rstb_n && wstb_lo_n && wstb_hi_n && sel_n == 4'hF, "R1 strobes and selects idle",
        {rstb_n, wstb_lo_n, wstb_hi_n, sel_n}, 7'h7F);
    chk(!addr_lat && !done && hold_ack_n && ctl_oe, "R1 control idle",
        {addr_lat, done, hold_ack_n, ctl_oe}, 4'b0011);

    // hold granted from idle, then released with a queued access
    hold_req_n = 1'b0;
    step();
    chk(!hold_ack_n && !ctl_oe && !dat_oe, "R6 hold from idle", {hold_ack_n, ctl_oe, dat_oe}, 0);
    access(24'h2000A4, 16'hBEEF, 2'b11, 1'b1, 1'b0, 3'b000, 0, 0);
    // directed corners
    access(24'h300011, 16'h5AA5, 2'b11, 1'b0, 1'b1, 3'b000, 1, 0);
    access(24'h3000F3, 16'hC3D2, 2'b10, 1'b1, 1'b1, 3'b000, 0, 0);
    access(24'h200102, 16'h1234, 2'b11, 1'b1, 1'b0, 3'b001, 1, 1);
    access(24'h050000, 16'h7777, 2'b01, 1'b0, 1'b0, 3'b000, 0, 0);
    access(24'h1000F0, 16'h9182, 2'b11, 1'b0, 1'b0, 3'b111, 1, 0);
    access(24'h400040, 16'hA0B1, 2'b10, 1'b0, 1'b0, 3'b100, 1, 1);

    for (int n = 0; n < 160; n++) begin
      logic [23:0] a;
      int r;
      r = $urandom % 6;
      if (r == 5) a = 24'h010000 + 24'($urandom % 24'h0F0000);
      else        a = 24'h100000 * 24'(r + 1) + 24'($urandom % 24'h100000);
      if (r == 4) a = 24'h050000 + 24'($urandom % 24'h10000);
      access(a, 16'($urandom), 2'(1 + $urandom % 3), 1'($urandom), ($urandom % 4 == 0),
             3'($urandom), ($urandom % 2 == 0), ($urandom % 5 == 0));
    end
    if (!hold_ack_n) begin
      hold_req_n = 1'b1;
      step();
      chk(hold_ack_n && ctl_oe, "R7 final release", {hold_ack_n, ctl_oe}, 2'b11);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule